// File: doc/BRIEF.md
# Deferred Condition-Code Resolver

This block turns a deferred flag record into a packed condition-code word. A processor pipeline that postpones flag computation stores three things after each flag-setting operation: an operation tag, the result, and one source operand. When a later instruction needs the flags, the caller presents that record here. The block recovers the missing first operand arithmetically and derives carry and overflow from it, so no adder carry chain has to be kept live.

The record is taken when `in_valid` is high. On the next clock edge the packed flags are registered and `out_valid` pulses for one cycle. There is no back-pressure. The block accepts a record on every cycle, and the caller must take each result in the cycle it appears. An unrecognised tag produces a one-cycle `out_err` pulse instead of a result.

The following are left to the caller:
- tracking of the extend flag;
- the sticky-zero merge across multi-word operations;
- instruction decode.

Top module: `lcc_flag_eval`

## Requirements
- R1: A record with a known tag (0 to 8) strobed by `in_valid` produces `out_valid` high for exactly the next cycle. Without a strobe, `out_valid` and `out_err` stay low and `out_flags` keeps its value.
- R2: Tag 0 (packed) copies `in_res` unchanged, all bits, to `out_flags`.
- R3: For tags 1 to 8, the flag bits are C=bit0, V=bit1, Z=bit2 and N=bit3. All bits above bit 3 are zero. Z is set when the result at the operating width is zero. N is set only when that result is nonzero and its top bit is set.
- R4: Tag 1 (logic) sets only N and Z from the full-width result. C and V are 0.
- R5: Tag 2 (add) first recovers op1 as res minus src. C is set when res is unsigned-less-than src. V is the top bit of (src^res) & ~(op1^src).
- R6: Tag 3 (subtract) first recovers op1 as res plus src. C is set when op1 is unsigned-less-than src. V is the top bit of (op1^res) & (op1^src).
- R7: Tag 4 (byte compare) applies the R6 rule to bits 7:0 only, for N, Z, C and V.
- R8: Tag 5 (word compare) applies the R6 rule to bits 15:0 only, for N, Z, C and V.
- R9: Tag 6 (add with extend) first recovers op1 as res minus src minus 1. C is set when res is unsigned-less-than-or-equal to src. V follows the R5 formula.
- R10: Tag 7 (subtract with extend) first recovers op1 as res plus src plus 1. C is set when op1 is unsigned-less-than-or-equal to src. V follows the R6 formula.
- R11: Tag 8 (shift) sets N and Z from the full-width result. C is set when src is nonzero. V is 0.
- R12: A strobed tag of 9 to 15 makes `out_err` pulse high for one cycle and leaves `out_valid` low. `out_flags` keeps its previous value.
- R13: While `rst_n` is low, `out_flags`, `out_valid` and `out_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record strobe |
| in_tag | input | 4 | Operation tag |
| in_res | input | WIDTH | Stored result operand |
| in_src | input | WIDTH | Stored source operand |
| out_valid | output | 1 | One-cycle pulse when flags are updated |
| out_flags | output | WIDTH | Packed flag word, or pass-through value for tag 0 |
| out_err | output | 1 | One-cycle pulse for an unknown tag |

## Verification
The bench uses the default widths: a 32-bit datapath with 8-bit and 16-bit compare lanes. These widths let the vectors place operands exactly on the signed boundaries 0x7FFFFFFF/0x80000000, 0x7F/0x80 and 0x8000. The narrow-compare vectors load junk into the upper bits, so a compare that used the full-width result would give visibly wrong N and Z. Both extend variants are exercised at the equality point, where their carry differs from the plain rule.

// File: rtl/lcc_pkg.sv
`timescale 1ns/1ps
package lcc_pkg;
  localparam int TAG_W = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_PACKED = 4'd0,
    TAG_LOGIC  = 4'd1,
    TAG_ADD    = 4'd2,
    TAG_SUB    = 4'd3,
    TAG_CMPB   = 4'd4,
    TAG_CMPW   = 4'd5,
    TAG_ADDX   = 4'd6,
    TAG_SUBX   = 4'd7,
    TAG_SHIFT  = 4'd8
  } lcc_tag_e;

  // Packed order puts n at bit 3 down to c at bit 0.
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } lcc_flags_t;

  localparam int FLAG_BITS = 4;
  localparam int POS_C = 0;
  localparam int POS_V = 1;
  localparam int POS_Z = 2;
  localparam int POS_N = 3;
endpackage

// File: rtl/lcc_nz.sv
`timescale 1ns/1ps
module lcc_nz #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         n,
  output logic         z
);
  always_comb begin
    z = (val == '0);
    n = !z && val[W-1];
  end
endmodule

// File: rtl/lcc_sub_rule.sv
`timescale 1ns/1ps
module lcc_sub_rule
  import lcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] src,
  input  logic         ext,
  output lcc_flags_t   flags
);
  logic [W-1:0] op1;
  logic n_w, z_w;

  lcc_nz #(.W(W)) u_nz (.val(res), .n(n_w), .z(z_w));

  always_comb begin
    // Minuend recovered from difference plus subtrahend (plus borrow-in).
    op1     = res + src + {{(W-1){1'b0}}, ext};
    flags.n = n_w;
    flags.z = z_w;
    flags.c = ext ? (op1 <= src) : (op1 < src);
    flags.v = ((op1 ^ res) & (op1 ^ src)) >> (W-1) != '0;
  end
endmodule

// File: rtl/lcc_add_rule.sv
`timescale 1ns/1ps
module lcc_add_rule
  import lcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] src,
  input  logic         ext,
  output lcc_flags_t   flags
);
  logic [W-1:0] op1;
  logic n_w, z_w;

  lcc_nz #(.W(W)) u_nz (.val(res), .n(n_w), .z(z_w));

  always_comb begin
    // First addend recovered from sum minus second addend (minus carry-in).
    op1     = res - src - {{(W-1){1'b0}}, ext};
    flags.n = n_w;
    flags.z = z_w;
    flags.c = ext ? (res <= src) : (res < src);
    flags.v = ((src ^ res) & ~(op1 ^ src)) >> (W-1) != '0;
  end
endmodule

// File: rtl/lcc_flag_eval.sv
`timescale 1ns/1ps
module lcc_flag_eval
  import lcc_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [WIDTH-1:0]  in_res,
  input  logic [WIDTH-1:0]  in_src,
  output logic              out_valid,
  output logic [WIDTH-1:0]  out_flags,
  output logic              out_err
);
  localparam int N_SUB = 4;   // sub, cmpb, cmpw, subx
  localparam int N_ADD = 2;   // add, addx
  localparam int PAD_W = WIDTH - FLAG_BITS;

  function automatic int sub_width(input int idx);
    case (idx)
      1:       return BYTE_W;
      2:       return HALF_W;
      default: return WIDTH;
    endcase
  endfunction

  lcc_flags_t sub_f [N_SUB];
  lcc_flags_t add_f [N_ADD];
  lcc_flags_t next_f;
  logic       full_n, full_z;
  logic       tag_known;

  genvar g;
  generate
    for (g = 0; g < N_SUB; g++) begin : g_sub
      localparam int SW = sub_width(g);
      lcc_sub_rule #(.W(SW)) u_rule (
        .res   (in_res[SW-1:0]),
        .src   (in_src[SW-1:0]),
        .ext   (g == N_SUB-1),
        .flags (sub_f[g])
      );
    end
    for (g = 0; g < N_ADD; g++) begin : g_add
      lcc_add_rule #(.W(WIDTH)) u_rule (
        .res   (in_res),
        .src   (in_src),
        .ext   (g == 1),
        .flags (add_f[g])
      );
    end
  endgenerate

  lcc_nz #(.W(WIDTH)) u_full_nz (.val(in_res), .n(full_n), .z(full_z));

  always_comb begin
    next_f    = '0;
    tag_known = 1'b1;
    case (in_tag)
      TAG_PACKED: next_f = '0;
      TAG_LOGIC:  begin next_f.n = full_n; next_f.z = full_z; end
      TAG_ADD:    next_f = add_f[0];
      TAG_SUB:    next_f = sub_f[0];
      TAG_CMPB:   next_f = sub_f[1];
      TAG_CMPW:   next_f = sub_f[2];
      TAG_ADDX:   next_f = add_f[1];
      TAG_SUBX:   next_f = sub_f[3];
      TAG_SHIFT:  begin
        next_f.n = full_n;
        next_f.z = full_z;
        next_f.c = (in_src != '0);
      end
      default:    tag_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_flags <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid && tag_known;
      out_err   <= in_valid && !tag_known;
      if (in_valid && tag_known) begin
        if (in_tag == TAG_PACKED) out_flags <= in_res;
        else                      out_flags <= {{PAD_W{1'b0}}, next_f};
      end
    end
  end

  // Assertions
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag <= TAG_SHIFT) |=> (out_valid && !out_err));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_flags) && !out_valid && !out_err));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_PACKED) |=> (out_flags == $past(in_res)));

  p_nz_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag != TAG_PACKED && in_tag <= TAG_SHIFT) |=>
      (!(out_flags[POS_N] && out_flags[POS_Z]) &&
       (out_flags >> FLAG_BITS) == '0));

  p_shift_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_SHIFT) |=>
      (out_flags[POS_C] == ($past(in_src) != '0)) && !out_flags[POS_V]);

  p_bad_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag > TAG_SHIFT) |=>
      (out_err && !out_valid && $stable(out_flags)));
endmodule

// File: tb/lcc_flag_eval_test.sv
`timescale 1ns/1ps
module lcc_flag_eval_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   in_tag = '0;
  logic [W-1:0] in_res = '0;
  logic [W-1:0] in_src = '0;
  logic         out_valid;
  logic [W-1:0] out_flags;
  logic         out_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcc_flag_eval uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_res(in_res), .in_src(in_src), .out_valid(out_valid),
    .out_flags(out_flags), .out_err(out_err)
  );

  // {tag, res, src, expected NZVC}
  localparam logic [71:0] VEC [23] = '{
    {4'd1, 32'h00000000, 32'h00000007, 4'h4},
    {4'd1, 32'h80000000, 32'h00000000, 4'h8},
    {4'd1, 32'h00000005, 32'hFFFFFFFF, 4'h0},
    {4'd2, 32'h00000000, 32'h00000001, 4'h5},
    {4'd2, 32'h80000000, 32'h00000001, 4'hA},
    {4'd2, 32'h00000003, 32'h00000001, 4'h0},
    {4'd3, 32'hFFFFFFFF, 32'h00000002, 4'h9},
    {4'd3, 32'h7FFFFFFF, 32'h00000001, 4'h2},
    {4'd3, 32'h00000000, 32'h00000005, 4'h4},
    {4'd4, 32'hFFFFFF00, 32'h00000001, 4'h4},
    {4'd4, 32'h1234567F, 32'hFFFFFF01, 4'h2},
    {4'd4, 32'h000000FF, 32'h00000001, 4'h9},
    {4'd5, 32'h00018000, 32'h00008000, 4'hB},
    {4'd5, 32'hFFFF0000, 32'h12340000, 4'h4},
    {4'd6, 32'h00000000, 32'h00000000, 4'h5},
    {4'd6, 32'h80000000, 32'h00000000, 4'hA},
    {4'd6, 32'h00000003, 32'h00000001, 4'h0},
    {4'd7, 32'hFFFFFFFF, 32'h00000000, 4'h9},
    {4'd7, 32'h7FFFFFFF, 32'h00000000, 4'h2},
    {4'd7, 32'h00000000, 32'h00000004, 4'h4},
    {4'd8, 32'h00000000, 32'h00000001, 4'h5},
    {4'd8, 32'h80000000, 32'h00000000, 4'h8},
    {4'd8, 32'h00000001, 32'h00000000, 4'h0}
  };

  function automatic string req_of(input logic [3:0] t);
    case (t)
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe one record; on return the registered output is visible.
  task automatic apply(input logic [3:0] t, input logic [W-1:0] r,
                       input logic [W-1:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_tag = t; in_res = r; in_src = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", {out_flags[W-3:0], out_valid, out_err}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 23; i++) begin
      logic [71:0] v;
      v = VEC[i];
      apply(v[71:68], v[67:36], v[35:4]);
      // R3 also covered: upper bits must be zero
      check(req_of(v[71:68]), out_flags, {28'd0, v[3:0]});
      check("R1", {31'd0, out_valid}, 32'd1);
    end

    // R2: packed pass-through of every bit
    apply(4'd0, 32'hDEADBEEF, 32'h0);
    check("R2", out_flags, 32'hDEADBEEF);

    // R1: idle cycles keep flags, no pulses
    @(negedge clk);
    check("R1", out_flags, 32'hDEADBEEF);
    check("R1", {30'd0, out_valid, out_err}, 32'd0);

    // R12: unknown tags leave flags and pulse error once
    apply(4'd1, 32'h80000000, 32'h0);
    apply(4'd9, 32'h0, 32'h0);
    check("R12", out_flags, 32'h8);
    check("R12", {30'd0, out_valid, out_err}, 32'd1);
    @(negedge clk);
    check("R12", {31'd0, out_err}, 32'd0);
    apply(4'd15, 32'h12345678, 32'h1);
    check("R12", {30'd0, out_valid, out_err}, 32'd1);
    check("R12", out_flags, 32'h8);

    // R1: back-to-back strobes, one result per cycle
    @(negedge clk);
    in_valid = 1'b1; in_tag = 4'd1; in_res = 32'h0; in_src = 32'h0;
    @(negedge clk);
    check("R1", out_flags, 32'h4);
    in_tag = 4'd8; in_res = 32'h1; in_src = 32'h3;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", out_flags, 32'h1);
    check("R1", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);

    // R13: reset clears a nonzero state
    rst_n = 1'b0;
    @(negedge clk);
    check("R13", out_flags, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule